// File: doc/BRIEF.md
# Dual-Limit Watchdog Status Register

This block watches the stream of conversion results coming out of an instruction sequencer. Each result arrives with the index of the instruction that produced it and that instruction's watchdog flag. Every instruction has two threshold words. Each word holds a signed level and a direction bit that selects either an "above" test or a "below" test. When a watched result crosses either of its instruction's thresholds, the matching bit of a 16-bit status word is latched.

The bit position tells the host two things: which instruction tripped and which of the two limits it crossed. Bits stay set until the host reads the word. The read strobe clears all of them, except that a trip landing in the same cycle as the read survives. Thresholds arrive as static configuration buses. No register write path sits inside the block.

Top module: `wdog_limit_status`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `stat_word` is 0.
- R2: Bit k of `stat_word` (k = 0..7) is set when a watched result from instruction k meets the condition in instruction k's first threshold word, `lim_a_cfg[14k+13:14k]`.
- R3: Bit 8+k of `stat_word` is set when a watched result from instruction k meets the condition in instruction k's second threshold word, `lim_b_cfg[14k+13:14k]`.
- R4: When bit 13 of a threshold word is 1, the condition is met only when the result is strictly greater than bits 12:0 of the word. Both values are read as 13-bit two's complement. A result equal to the level does not trip.
- R5: When bit 13 of a threshold word is 0, the condition is met only when the result is strictly less than bits 12:0 of the word, read as two's complement. A result equal to the level does not trip.
- R6: A cycle with `res_vld` low, or with `res_watch` low, never sets any status bit.
- R7: A set status bit stays set in every later cycle until a read strobe is seen. Later trips add bits and never remove any.
- R8: A cycle with `stat_rd` high and no trip clears all 16 bits. The word reads 0 from the next cycle.
- R9: When a trip and `stat_rd` fall in the same cycle, the old bits are cleared and the newly tripped bits are set in the next cycle.
- R10: A trip sampled at a rising clock edge is visible on `stat_word` immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_vld | input | 1 | Result strobe, one cycle per conversion result |
| res_value | input | 13 | Conversion result, two's complement |
| res_slot | input | 3 | Index of the instruction that produced the result |
| res_watch | input | 1 | Watchdog flag of that instruction |
| lim_a_cfg | input | 112 | Eight first-limit words, 14 bits each: bit 13 direction, bits 12:0 level |
| lim_b_cfg | input | 112 | Eight second-limit words, same layout |
| stat_rd | input | 1 | Status read strobe; clears the word |
| stat_word | output | 16 | Latched trip bits: 7:0 first limit, 15:8 second limit |

## Verification
A status read and a fresh trip can fall in the same clock cycle. These are the clearing function and the setting function. The bench builds a nonzero status word first. It then drives a watched, tripping result together with `stat_rd` and expects the next word to hold exactly the new trip bits. The plain-read case (no trip) and the accumulate case (no read) serve as its two neighbours. Threshold directions and levels are swept around each boundary so that every instruction slot exercises both limits.

// File: rtl/wdl_pkg.sv
package wdl_pkg;

    localparam int RES_W = 13;
    localparam int CFG_W = RES_W + 1;

    typedef logic signed [RES_W-1:0] res_t;

    typedef struct packed {
        logic                    above;
        logic signed [RES_W-1:0] level;
    } lim_cfg_t;

    function automatic logic lim_hit(input res_t v, input lim_cfg_t c);
        res_t lvl;
        lvl = c.level;
        return c.above ? (v > lvl) : (v < lvl);
    endfunction

endpackage

// File: rtl/wdl_limit_check.sv
module wdl_limit_check
    import wdl_pkg::*;
#(
    parameter int N_SLOT = 8,
    localparam int SW    = $clog2(N_SLOT)
) (
    input  logic            fire,
    input  res_t            value,
    input  logic [SW-1:0]   slot,
    input  lim_cfg_t        cfg [N_SLOT],
    output logic [N_SLOT-1:0] trip
);

    always_comb begin
        trip = '0;
        if (fire && lim_hit(value, cfg[slot]))
            trip[slot] = 1'b1;
    end

endmodule

// File: rtl/wdl_status_reg.sv
module wdl_status_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic         clr,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= (clr ? '0 : q) | set_vec;
    end

    // R7: bits persist without a read
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((q & $past(q)) == $past(q)));

    // R8: a read with no trip empties the word
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr && set_vec == '0) |=> (q == '0));

    // R9: a trip coinciding with a read survives it
    p_trip_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && set_vec != '0) |=> (q == $past(set_vec)));

endmodule

// File: rtl/wdog_limit_status.sv
module wdog_limit_status
    import wdl_pkg::*;
#(
    parameter int N_SLOT = 8,
    localparam int SW    = $clog2(N_SLOT),
    localparam int N_LIM = 2,
    localparam int ST_W  = N_LIM * N_SLOT
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    res_vld,
    input  logic [RES_W-1:0]        res_value,
    input  logic [SW-1:0]           res_slot,
    input  logic                    res_watch,
    input  logic [N_SLOT*CFG_W-1:0] lim_a_cfg,
    input  logic [N_SLOT*CFG_W-1:0] lim_b_cfg,
    input  logic                    stat_rd,
    output logic [ST_W-1:0]         stat_word
);

    lim_cfg_t             cfg [N_LIM][N_SLOT];
    logic [N_SLOT-1:0]    trip [N_LIM];
    logic [ST_W-1:0]      set_vec;
    logic                 fire;

    assign fire = res_vld && res_watch;

    genvar gl, gs;
    generate
        for (gs = 0; gs < N_SLOT; gs++) begin : g_unpack
            assign cfg[0][gs] = lim_a_cfg[gs*CFG_W +: CFG_W];
            assign cfg[1][gs] = lim_b_cfg[gs*CFG_W +: CFG_W];
        end
        for (gl = 0; gl < N_LIM; gl++) begin : g_lim
            wdl_limit_check #(.N_SLOT(N_SLOT)) u_chk (
                .fire  (fire),
                .value (res_t'(res_value)),
                .slot  (res_slot),
                .cfg   (cfg[gl]),
                .trip  (trip[gl])
            );
            assign set_vec[gl*N_SLOT +: N_SLOT] = trip[gl];
        end
    endgenerate

    wdl_status_reg #(.W(ST_W)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr     (stat_rd),
        .q       (stat_word)
    );

    logic [ST_W-1:0] slot_mask;
    always_comb begin
        slot_mask = '0;
        slot_mask[res_slot]          = 1'b1;
        slot_mask[N_SLOT + res_slot] = 1'b1;
    end

    // R6: unwatched or absent results leave the word untouched
    p_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        (!fire && !stat_rd) |=> $stable(stat_word));

    // R2 / R3: a result only adds bits belonging to its own slot
    p_own_slot_r2: assert property (@(posedge clk) disable iff (rst)
        (!stat_rd) |=> ((stat_word & ~$past(stat_word) & ~$past(slot_mask)) == '0));

    // R10: any trip appears right after the sampling edge
    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((stat_word & $past(set_vec)) == $past(set_vec)));

endmodule

// File: tb/wdog_limit_status_bench.sv
module wdog_limit_status_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         res_vld;
    logic [12:0]  res_value;
    logic [2:0]   res_slot;
    logic         res_watch;
    logic [111:0] lim_a_cfg;
    logic [111:0] lim_b_cfg;
    logic         stat_rd;
    logic [15:0]  stat_word;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    wdog_limit_status u_wdog_limit_status (
        .clk(clk), .rst(rst), .res_vld(res_vld), .res_value(res_value),
        .res_slot(res_slot), .res_watch(res_watch), .lim_a_cfg(lim_a_cfg),
        .lim_b_cfg(lim_b_cfg), .stat_rd(stat_rd), .stat_word(stat_word)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit hit(input int v, input logic [13:0] c);
        int lvl;
        lvl = $signed(c[12:0]);
        return c[13] ? (v > lvl) : (v < lvl);
    endfunction

    task automatic set_cfg(input int k, input bit second, input bit above, input int lvl);
        logic [13:0] w;
        w = {above, lvl[12:0]};
        if (second) lim_b_cfg[14*k +: 14] = w;
        else        lim_a_cfg[14*k +: 14] = w;
    endtask

    task automatic pulse(input bit vld, input bit watch, input int slot, input int val, input bit rd);
        @(negedge clk);
        res_vld   = vld;
        res_watch = watch;
        res_slot  = slot[2:0];
        res_value = val[12:0];
        stat_rd   = rd;
        @(negedge clk);
        res_vld   = 1'b0;
        res_watch = 1'b0;
        stat_rd   = 1'b0;
    endtask

    task automatic clear_word();
        pulse(1'b0, 1'b0, 0, 0, 1'b1);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] exp;
        int lvl;
        int v;
        rst = 1'b1; res_vld = 0; res_watch = 0; res_slot = 0;
        res_value = 0; stat_rd = 0; lim_a_cfg = '0; lim_b_cfg = '0;
        repeat (3) @(negedge clk);
        check("R1 in reset", stat_word, 16'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", stat_word, 16'h0);

        // Boundary sweep over directions, slots, limits and offsets
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 8; k++) begin
                set_cfg(k, 1'b0, p[0], (k - 4) * 37 + p * 5);
                set_cfg(k, 1'b1, p[1], 200 - k * 61);
            end
            for (int k = 0; k < 8; k++) begin
                for (int which = 0; which < 2; which++) begin
                    lvl = (which == 0) ? ((k - 4) * 37 + p * 5) : (200 - k * 61);
                    for (int d = -2; d <= 2; d++) begin
                        v = lvl + d;
                        clear_word();
                        pulse(1'b1, 1'b1, k, v, 1'b0);
                        exp = '0;
                        exp[k]     = hit(v, lim_a_cfg[14*k +: 14]);
                        exp[8 + k] = hit(v, lim_b_cfg[14*k +: 14]);
                        check("R2 R3 R4 R5 R10 sweep", stat_word, exp);
                    end
                end
                clear_word();
                pulse(1'b1, 1'b0, k, lvl + 900, 1'b0);
                check("R6 watch low", stat_word, 16'h0);
                pulse(1'b0, 1'b1, k, lvl - 900, 1'b0);
                check("R6 valid low", stat_word, 16'h0);
            end
        end

        // Known configuration: A above 0, B below 0
        for (int k = 0; k < 8; k++) begin
            set_cfg(k, 1'b0, 1'b1, 0);
            set_cfg(k, 1'b1, 1'b0, 0);
        end
        clear_word();
        pulse(1'b1, 1'b1, 2, 100, 1'b0);
        check("R2 slot2 above", stat_word, 16'h0004);
        repeat (4) @(negedge clk);
        check("R7 held idle", stat_word, 16'h0004);
        pulse(1'b1, 1'b1, 5, -100, 1'b0);
        check("R7 R3 accumulate", stat_word, 16'h2004);
        pulse(1'b1, 1'b0, 6, 100, 1'b0);
        check("R6 unwatched keeps word", stat_word, 16'h2004);
        pulse(1'b1, 1'b1, 2, 0, 1'b0);
        check("R4 R5 equal level no change", stat_word, 16'h2004);
        pulse(1'b1, 1'b1, 3, 100, 1'b1);
        check("R9 trip wins over read", stat_word, 16'h0008);
        pulse(1'b1, 1'b1, 7, -5, 1'b0);
        check("R7 accumulate after R9", stat_word, 16'h8008);
        clear_word();
        check("R8 read clears", stat_word, 16'h0);
        repeat (2) @(negedge clk);
        check("R8 stays clear", stat_word, 16'h0);

        // Range extremes
        set_cfg(1, 1'b0, 1'b1, 4095);
        set_cfg(1, 1'b1, 1'b0, -4096);
        pulse(1'b1, 1'b1, 1, 4095, 1'b0);
        check("R4 max never above max", stat_word, 16'h0);
        pulse(1'b1, 1'b1, 1, -4096, 1'b0);
        check("R5 min never below min", stat_word, 16'h0);
        set_cfg(1, 1'b0, 1'b1, -4096);
        set_cfg(1, 1'b1, 1'b0, 4095);
        pulse(1'b1, 1'b1, 1, -4095, 1'b0);
        check("R4 R5 near extremes", stat_word, 16'h0202);

        summary();
        $finish;
    end

endmodule